// File: doc/BRIEF.md
# Register Rename Map with Rollback History

This block renames the registers of a small out-of-order core that runs several hardware threads. Each thread has its own table that maps architectural registers to physical registers. All threads draw from one shared pool of free physical registers. Every cycle the block takes a group of up to `WIDTH` decoded instructions from one thread. It returns the physical tags of their sources, and it gives each instruction that writes a register a fresh physical register.

Each allocation is logged in a per-thread ordered history. A log entry holds the sequence number, the architectural register, the new physical tag and the tag it displaced. A commit retires the oldest entry and hands the displaced tag back to the pool. A squash undoes entries from the young end of the log, one per cycle, until it reaches the given sequence number. Each undone entry restores its old mapping and returns its new tag to the pool. No checkpoints are stored.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i of thread t reads as physical tag t*NUM_ARCH+i, and the pool holds tags NUM_THREADS*NUM_ARCH up to NUM_PHYS-1, handed out in ascending order.
- R2: Architectural index 0 is hardwired. A source 0 yields tag 0. A destination 0 yields destination tag 0 and takes nothing from the pool.
- R3: Every accepted slot with a nonzero destination takes the next tag from the head of the pool, in slot order (slot 0 first). Tags returned to the pool join at its tail.
- R4: A source sees the destination of any lower-numbered slot in the same group that writes the same register. A source of an instruction never sees that instruction's own destination.
- R5: `rn_ready` is low, and the group is dropped with nothing changed, when the pool holds fewer tags than the group's nonzero destinations, or when the thread's history would then exceed HIST_DEPTH entries.
- R6: A squash for thread t and sequence s raises `sq_busy` on the next cycle. On each busy cycle it undoes one entry of thread t with a sequence number above s, youngest first, restoring the displaced mapping and returning the new tag to the pool. The cycle it finds no such entry, it drops `sq_busy`, so a walk over n entries stays busy for n+1 cycles.
- R7: A commit whose sequence number equals the oldest history entry of its thread removes that entry and returns the tag it displaced to the pool. A commit with any other number has no effect.
- R8: Threads keep separate maps: renaming in one thread never changes what another thread reads.
- R9: Output tags and `out_valid` are registered. They appear on the cycle after acceptance, and `out_valid` is zero after any cycle without an accepted group.
- R10: `rn_ready` is low while `sq_valid` is high and while `sq_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | WIDTH | Slot valid bits of the incoming group |
| in_tid | input | TW | Thread of the incoming group |
| in_src_a | input | WIDTH x AW | First source index per slot |
| in_src_b | input | WIDTH x AW | Second source index per slot |
| in_dst | input | WIDTH x AW | Destination index per slot (0 = none) |
| in_seq | input | WIDTH x SEQ_W | Sequence number per slot |
| rn_ready | output | 1 | Group is accepted this cycle |
| out_valid | output | WIDTH | Registered slot valid bits |
| out_src_a_tag | output | WIDTH x PW | Physical tag of first source |
| out_src_b_tag | output | WIDTH x PW | Physical tag of second source |
| out_dst_tag | output | WIDTH x PW | Newly allocated destination tag, 0 if none |
| cm_valid | input | 1 | Commit notification |
| cm_tid | input | TW | Commit thread |
| cm_seq | input | SEQ_W | Sequence number being committed |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TW | Squash thread |
| sq_seq | input | SEQ_W | Entries younger than this are undone |
| sq_busy | output | 1 | Squash walk in progress |

## Verification
The hardest situation to reach is a stall for lack of free tags while the thread still has history room, or the reverse. Every live tag sits in some history, so the two limits usually trip together. The bench fills one thread up to its history limit and then fills the second thread until the pool is empty. It then sends a commit with a wrong number, followed by a correct one. The rest of the run is random groups, commits and squashes. A bench model of the maps, the pool order and the logs predicts every tag and every walk length.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WALK = 1'b1
  } sq_state_e;

  // Modular add for circular pointers of any depth; step must be below depth.
  function automatic int unsigned rn_wrap(int unsigned base, int unsigned step,
                                          int unsigned depth);
    int unsigned s;
    s = base + step;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter int NUM_PHYS  = 32,
  parameter int INIT_BASE = 16,
  parameter int WIDTH     = 2,
  localparam int PW       = $clog2(NUM_PHYS),
  localparam int CW       = $clog2(NUM_PHYS + 1),
  localparam int NW       = $clog2(WIDTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NW-1:0]             alloc_n,
  output logic [WIDTH-1:0][PW-1:0]  peek,
  output logic [CW-1:0]             count,
  input  logic                      rel_a_en,
  input  logic [PW-1:0]             rel_a_tag,
  input  logic                      rel_b_en,
  input  logic [PW-1:0]             rel_b_tag
);
  localparam int INIT_CNT = NUM_PHYS - INIT_BASE;
  localparam int IW       = PW;

  logic [PW-1:0] slots [NUM_PHYS];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] wr_b_idx;

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      peek[k] = slots[IW'(rn_wrap(32'(head_q), k, NUM_PHYS))];
    end
    wr_b_idx = IW'(rn_wrap(32'(tail_q), rel_a_en ? 1 : 0, NUM_PHYS));
  end

  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        slots[i] <= (i < INIT_CNT) ? PW'(INIT_BASE + i) : '0;
      end
      head_q <= '0;
      tail_q <= IW'(INIT_CNT % NUM_PHYS);
      cnt_q  <= CW'(INIT_CNT);
    end else begin
      if (rel_a_en) slots[tail_q]   <= rel_a_tag;
      if (rel_b_en) slots[wr_b_idx] <= rel_b_tag;
      head_q <= IW'(rn_wrap(32'(head_q), 32'(alloc_n), NUM_PHYS));
      tail_q <= IW'(rn_wrap(32'(tail_q), (rel_a_en ? 1 : 0) + (rel_b_en ? 1 : 0), NUM_PHYS));
      cnt_q  <= cnt_q - CW'(alloc_n) + CW'(rel_a_en) + CW'(rel_b_en);
    end
  end

endmodule

// File: rtl/rn_history.sv
module rn_history
  import rn_pkg::*;
#(
  parameter int AW    = 3,
  parameter int PW    = 5,
  parameter int SW    = 16,
  parameter int DEPTH = 12,
  parameter int WIDTH = 2,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WIDTH-1:0]          push_en,
  input  logic [WIDTH-1:0][AW-1:0]  push_arch,
  input  logic [WIDTH-1:0][PW-1:0]  push_new,
  input  logic [WIDTH-1:0][PW-1:0]  push_prev,
  input  logic [WIDTH-1:0][SW-1:0]  push_seq,
  input  logic                      pop_oldest,
  input  logic                      pop_youngest,
  output logic [CW-1:0]             count,
  output logic [SW-1:0]             old_seq,
  output logic [PW-1:0]             old_prev,
  output logic [AW-1:0]             yng_arch,
  output logic [PW-1:0]             yng_new,
  output logic [PW-1:0]             yng_prev,
  output logic [SW-1:0]             yng_seq
);
  logic [AW-1:0] e_arch [DEPTH];
  logic [PW-1:0] e_new  [DEPTH];
  logic [PW-1:0] e_prev [DEPTH];
  logic [SW-1:0] e_seq  [DEPTH];

  logic [IW-1:0] head_q, tail_q, yidx;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] slot_idx [WIDTH];
  int unsigned   n_push;

  always_comb begin
    n_push = 0;
    for (int k = 0; k < WIDTH; k++) begin
      slot_idx[k] = IW'(rn_wrap(32'(tail_q), n_push, DEPTH));
      if (push_en[k]) n_push = n_push + 1;
    end
    yidx = IW'(rn_wrap(32'(tail_q), DEPTH - 1, DEPTH));
  end

  assign count    = cnt_q;
  assign old_seq  = e_seq[head_q];
  assign old_prev = e_prev[head_q];
  assign yng_arch = e_arch[yidx];
  assign yng_new  = e_new[yidx];
  assign yng_prev = e_prev[yidx];
  assign yng_seq  = e_seq[yidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_oldest) head_q <= IW'(rn_wrap(32'(head_q), 1, DEPTH));
      if (pop_youngest) tail_q <= yidx;
      else              tail_q <= IW'(rn_wrap(32'(tail_q), n_push, DEPTH));
      cnt_q <= cnt_q + CW'(n_push) - CW'(pop_oldest) - CW'(pop_youngest);
    end
  end

  // Entry storage carries no reset so that it maps onto plain memory.
  always_ff @(posedge clk) begin
    for (int k = 0; k < WIDTH; k++) begin
      if (push_en[k]) begin
        e_arch[slot_idx[k]] <= push_arch[k];
        e_new[slot_idx[k]]  <= push_new[k];
        e_prev[slot_idx[k]] <= push_prev[k];
        e_seq[slot_idx[k]]  <= push_seq[k];
      end
    end
  end

endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
  import rn_pkg::*;
#(
  parameter int NUM_ARCH    = 8,
  parameter int NUM_PHYS    = 32,
  parameter int NUM_THREADS = 2,
  parameter int WIDTH       = 2,
  parameter int HIST_DEPTH  = 12,
  parameter int SEQ_W       = 16,
  localparam int AW         = $clog2(NUM_ARCH),
  localparam int PW         = $clog2(NUM_PHYS),
  localparam int TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WIDTH-1:0]            in_valid,
  input  logic [TW-1:0]               in_tid,
  input  logic [WIDTH-1:0][AW-1:0]    in_src_a,
  input  logic [WIDTH-1:0][AW-1:0]    in_src_b,
  input  logic [WIDTH-1:0][AW-1:0]    in_dst,
  input  logic [WIDTH-1:0][SEQ_W-1:0] in_seq,
  output logic                        rn_ready,
  output logic [WIDTH-1:0]            out_valid,
  output logic [WIDTH-1:0][PW-1:0]    out_src_a_tag,
  output logic [WIDTH-1:0][PW-1:0]    out_src_b_tag,
  output logic [WIDTH-1:0][PW-1:0]    out_dst_tag,
  input  logic                        cm_valid,
  input  logic [TW-1:0]               cm_tid,
  input  logic [SEQ_W-1:0]            cm_seq,
  input  logic                        sq_valid,
  input  logic [TW-1:0]               sq_tid,
  input  logic [SEQ_W-1:0]            sq_seq,
  output logic                        sq_busy
);
  localparam int INIT_USED = NUM_THREADS * NUM_ARCH;
  localparam int HCW       = $clog2(HIST_DEPTH + 1);
  localparam int FCW       = $clog2(NUM_PHYS + 1);
  localparam int NW        = $clog2(WIDTH + 1);

  // Per-thread map tables.
  logic [PW-1:0] map_q [NUM_THREADS][NUM_ARCH];

  // History outputs per thread.
  logic [HCW-1:0]   h_cnt   [NUM_THREADS];
  logic [SEQ_W-1:0] h_oseq  [NUM_THREADS];
  logic [PW-1:0]    h_oprev [NUM_THREADS];
  logic [AW-1:0]    h_yarch [NUM_THREADS];
  logic [PW-1:0]    h_ynew  [NUM_THREADS];
  logic [PW-1:0]    h_yprev [NUM_THREADS];
  logic [SEQ_W-1:0] h_yseq  [NUM_THREADS];

  // Free pool.
  logic [WIDTH-1:0][PW-1:0] fl_peek;
  logic [FCW-1:0]           fl_count;
  logic [NW-1:0]            alloc_n;

  // Group decode.
  logic [WIDTH-1:0]          alloc;
  logic [NW-1:0]             n_dst;
  logic [NW-1:0]             off [WIDTH];
  logic [WIDTH-1:0][PW-1:0]  tag_a, tag_b, tag_new, tag_prev;
  logic                      accept;

  // Squash walk state.
  sq_state_e        sq_state_q;
  logic [TW-1:0]    sq_tid_q;
  logic [SEQ_W-1:0] sq_seq_q;
  logic             sq_step;
  logic             cm_hit;

  // Slot offsets into the pool and the number of allocations.
  always_comb begin
    n_dst = '0;
    for (int k = 0; k < WIDTH; k++) begin
      alloc[k] = in_valid[k] && (in_dst[k] != '0);
      off[k]   = n_dst;
      if (alloc[k]) n_dst = n_dst + NW'(1);
    end
  end

  assign rn_ready = (sq_state_q == SQ_IDLE) && !sq_valid &&
                    (FCW'(n_dst) <= fl_count) &&
                    ((32'(h_cnt[in_tid]) + 32'(n_dst)) <= HIST_DEPTH);
  assign accept   = rn_ready && (|in_valid);
  assign alloc_n  = accept ? n_dst : '0;

  // Lookups with intra-group forwarding from lower slots.
  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      tag_new[k]  = fl_peek[off[k]];
      tag_a[k]    = (in_src_a[k] == '0) ? '0 : map_q[in_tid][in_src_a[k]];
      tag_b[k]    = (in_src_b[k] == '0) ? '0 : map_q[in_tid][in_src_b[k]];
      tag_prev[k] = map_q[in_tid][in_dst[k]];
      for (int j = 0; j < WIDTH; j++) begin
        if (j < k && alloc[j]) begin
          if (in_dst[j] == in_src_a[k]) tag_a[k]    = fl_peek[off[j]];
          if (in_dst[j] == in_src_b[k]) tag_b[k]    = fl_peek[off[j]];
          if (in_dst[j] == in_dst[k])   tag_prev[k] = fl_peek[off[j]];
        end
      end
    end
  end

  // Commit and squash decisions.
  assign cm_hit  = cm_valid && (h_cnt[cm_tid] != '0) && (h_oseq[cm_tid] == cm_seq);
  assign sq_step = (sq_state_q == SQ_WALK) && (h_cnt[sq_tid_q] != '0) &&
                   (h_yseq[sq_tid_q] > sq_seq_q);
  assign sq_busy = (sq_state_q == SQ_WALK);

  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_hist
      logic [WIDTH-1:0] push_en_t;
      assign push_en_t = (accept && (in_tid == TW'(t))) ? alloc : '0;

      rn_history #(
        .AW(AW), .PW(PW), .SW(SEQ_W), .DEPTH(HIST_DEPTH), .WIDTH(WIDTH)
      ) u_hist (
        .clk          (clk),
        .rst          (rst),
        .push_en      (push_en_t),
        .push_arch    (in_dst),
        .push_new     (tag_new),
        .push_prev    (tag_prev),
        .push_seq     (in_seq),
        .pop_oldest   (cm_hit && (cm_tid == TW'(t))),
        .pop_youngest (sq_step && (sq_tid_q == TW'(t))),
        .count        (h_cnt[t]),
        .old_seq      (h_oseq[t]),
        .old_prev     (h_oprev[t]),
        .yng_arch     (h_yarch[t]),
        .yng_new      (h_ynew[t]),
        .yng_prev     (h_yprev[t]),
        .yng_seq      (h_yseq[t])
      );
    end
  endgenerate

  rn_free_list #(
    .NUM_PHYS(NUM_PHYS), .INIT_BASE(INIT_USED), .WIDTH(WIDTH)
  ) u_free (
    .clk       (clk),
    .rst       (rst),
    .alloc_n   (alloc_n),
    .peek      (fl_peek),
    .count     (fl_count),
    .rel_a_en  (cm_hit),
    .rel_a_tag (h_oprev[cm_tid]),
    .rel_b_en  (sq_step),
    .rel_b_tag (h_ynew[sq_tid_q])
  );

  // Map table update: allocations when renaming, restores when walking back.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        for (int i = 0; i < NUM_ARCH; i++) begin
          map_q[t][i] <= PW'(t * NUM_ARCH + i);
        end
      end
    end else begin
      if (accept) begin
        for (int k = 0; k < WIDTH; k++) begin
          if (alloc[k]) map_q[in_tid][in_dst[k]] <= tag_new[k];
        end
      end
      if (sq_step) map_q[sq_tid_q][h_yarch[sq_tid_q]] <= h_yprev[sq_tid_q];
    end
  end

  // Squash control.
  always_ff @(posedge clk) begin
    if (rst) begin
      sq_state_q <= SQ_IDLE;
      sq_tid_q   <= '0;
      sq_seq_q   <= '0;
    end else if (sq_valid) begin
      sq_state_q <= SQ_WALK;
      sq_tid_q   <= sq_tid;
      sq_seq_q   <= sq_seq;
    end else if ((sq_state_q == SQ_WALK) && !sq_step) begin
      sq_state_q <= SQ_IDLE;
    end
  end

  // Registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= '0;
      out_src_a_tag <= '0;
      out_src_b_tag <= '0;
      out_dst_tag   <= '0;
    end else begin
      out_valid     <= accept ? in_valid : '0;
      out_src_a_tag <= tag_a;
      out_src_b_tag <= tag_b;
      for (int k = 0; k < WIDTH; k++) begin
        out_dst_tag[k] <= alloc[k] ? tag_new[k] : '0;
      end
    end
  end

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int WIDTH = 2,
  parameter int AW    = 3,
  parameter int PW    = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic [WIDTH-1:0]         in_valid,
  input logic [WIDTH-1:0][AW-1:0] in_src_a,
  input logic [WIDTH-1:0][AW-1:0] in_dst,
  input logic                     rn_ready,
  input logic [WIDTH-1:0]         out_valid,
  input logic [WIDTH-1:0][PW-1:0] out_src_a_tag,
  input logic [WIDTH-1:0][PW-1:0] out_dst_tag,
  input logic                     sq_valid,
  input logic                     sq_busy
);
  logic acc;
  assign acc = rn_ready && (|in_valid);

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    sq_busy |-> !rn_ready); // R10
  AST_SQREQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> !rn_ready); // R10
  AST_SQ_STARTS: assert property (@(posedge clk) disable iff (rst)
    sq_valid |=> sq_busy); // R6
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (out_valid == '0)); // R9
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_valid == $past(in_valid))); // R9

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_slot
      AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
        (acc && in_valid[k] && (in_src_a[k] == '0)) |=> (out_src_a_tag[k] == '0)); // R2
      AST_ZERO_DST: assert property (@(posedge clk) disable iff (rst)
        (acc && in_valid[k] && (in_dst[k] == '0)) |=> (out_dst_tag[k] == '0)); // R2
    end
    if (WIDTH >= 2) begin : g_pair
      AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (acc && (in_valid[1:0] == 2'b11) && (in_dst[0] != '0) && (in_dst[1] != '0))
        |=> (out_dst_tag[0] != out_dst_tag[1])); // R3
      AST_GROUP_FWD: assert property (@(posedge clk) disable iff (rst)
        (acc && (in_valid[1:0] == 2'b11) && (in_dst[0] != '0) && (in_src_a[1] == in_dst[0]))
        |=> (out_src_a_tag[1] == out_dst_tag[0])); // R4
    end
  endgenerate

endmodule

bind rename_map_unit rn_checker #(.WIDTH(WIDTH), .AW(AW), .PW(PW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_src_a      (in_src_a),
  .in_dst        (in_dst),
  .rn_ready      (rn_ready),
  .out_valid     (out_valid),
  .out_src_a_tag (out_src_a_tag),
  .out_dst_tag   (out_dst_tag),
  .sq_valid      (sq_valid),
  .sq_busy       (sq_busy)
);

// File: tb/rename_map_unit_tb.sv
`timescale 1ns/1ps
module rename_map_unit_tb;
  localparam int NA = 8, NP = 32, NT = 2, W = 2, HD = 12, SW = 16;
  localparam int AW = 3, PW = 5, TW = 1;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0]          in_valid = '0;
  logic [TW-1:0]         in_tid = '0;
  logic [W-1:0][AW-1:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [W-1:0][SW-1:0]  in_seq = '0;
  logic                  rn_ready;
  logic [W-1:0]          out_valid;
  logic [W-1:0][PW-1:0]  out_src_a_tag, out_src_b_tag, out_dst_tag;
  logic                  cm_valid = 1'b0, sq_valid = 1'b0;
  logic [TW-1:0]         cm_tid = '0, sq_tid = '0;
  logic [SW-1:0]         cm_seq = '0, sq_seq = '0;
  logic                  sq_busy;

  rename_map_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_THREADS(NT), .WIDTH(W),
                    .HIST_DEPTH(HD), .SEQ_W(SW)) u_dut (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // Reference model.
  typedef struct { int arch; int nw; int pv; int seq; } hent_t;
  int    mmap [NT][NA];
  int    fq [$];
  hent_t hq [NT][$];
  int    seqctr = 1;

  // Expectations for the next cycle.
  bit pend = 0, e_acc = 0;
  int e_vld, e_a [W], e_b [W], e_d [W];
  string tag_src = "R4", tag_dst = "R3", tag_rdy = "R5";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    fq.delete();
    for (int t = 0; t < NT; t++) begin
      hq[t].delete();
      for (int i = 0; i < NA; i++) mmap[t][i] = t * NA + i;
    end
    for (int p = NT * NA; p < NP; p++) fq.push_back(p);
  endfunction

  task automatic check_prev();
    if (!pend) return;
    if (!e_acc) begin
      chk(out_valid == '0, "R9", int'(out_valid), 0);
    end else begin
      chk(int'(out_valid) == e_vld, "R9", int'(out_valid), e_vld);
      for (int k = 0; k < W; k++) begin
        if (e_vld[k]) begin
          chk(int'(out_src_a_tag[k]) == e_a[k], tag_src, int'(out_src_a_tag[k]), e_a[k]);
          chk(int'(out_src_b_tag[k]) == e_b[k], tag_src, int'(out_src_b_tag[k]), e_b[k]);
          chk(int'(out_dst_tag[k]) == e_d[k], tag_dst, int'(out_dst_tag[k]), e_d[k]);
        end
      end
    end
    pend = 0;
  endtask

  // One cycle: drive group plus optional commit/squash, predict, update model.
  task automatic do_cycle(input int t, input int vld, input int sa [W], input int sb [W],
                          input int d [W], input bit cv, input int ct, input int cs,
                          input bit sv, input int st, input int ss);
    int nd, off, nw [W];
    bit alloc [W], exp_rdy;
    @(negedge clk);
    check_prev();
    in_tid = TW'(t); in_valid = W'(vld);
    for (int k = 0; k < W; k++) begin
      in_src_a[k] = AW'(sa[k]); in_src_b[k] = AW'(sb[k]); in_dst[k] = AW'(d[k]);
      in_seq[k] = SW'(seqctr + k);
    end
    cm_valid = cv; cm_tid = TW'(ct); cm_seq = SW'(cs);
    sq_valid = sv; sq_tid = TW'(st); sq_seq = SW'(ss);
    #1;
    nd = 0;
    for (int k = 0; k < W; k++) begin
      alloc[k] = vld[k] && d[k] != 0;
      if (alloc[k]) nd++;
    end
    exp_rdy = !sv && (nd <= fq.size()) && (hq[t].size() + nd <= HD);
    chk(rn_ready == exp_rdy, sv ? "R10" : tag_rdy, int'(rn_ready), int'(exp_rdy));
    e_acc = exp_rdy && (vld != 0);
    e_vld = vld;
    if (e_acc) begin
      off = 0;
      for (int k = 0; k < W; k++) begin
        nw[k] = alloc[k] ? fq[off] : 0;
        if (alloc[k]) off++;
        e_a[k] = (sa[k] == 0) ? 0 : mmap[t][sa[k]];
        e_b[k] = (sb[k] == 0) ? 0 : mmap[t][sb[k]];
        e_d[k] = nw[k];
        if (alloc[k]) begin
          hq[t].push_back('{arch: d[k], nw: nw[k], pv: mmap[t][d[k]], seq: seqctr + k});
          mmap[t][d[k]] = nw[k];
        end
      end
      for (int k = 0; k < off; k++) void'(fq.pop_front());
      seqctr += W;
    end
    if (cv && hq[ct].size() > 0 && hq[ct][0].seq == cs) begin
      fq.push_back(hq[ct][0].pv);
      void'(hq[ct].pop_front());
    end
    pend = 1;
  endtask

  task automatic grp(input int t, input int vld, input int a0, input int b0, input int d0,
                     input int a1, input int b1, input int d1);
    int sa [W], sb [W], d [W];
    sa[0] = a0; sb[0] = b0; d[0] = d0; sa[1] = a1; sb[1] = b1; d[1] = d1;
    do_cycle(t, vld, sa, sb, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic commit_only(input int ct, input int cs);
    int z [W];
    z[0] = 0; z[1] = 0;
    do_cycle(0, 0, z, z, z, 1, ct, cs, 0, 0, 0);
  endtask

  task automatic idle();
    @(negedge clk);
    check_prev();
    in_valid = '0; cm_valid = 0; sq_valid = 0;
  endtask

  task automatic squash(input int st, input int ss);
    int z [W], n, cyc;
    z[0] = 1; z[1] = 2;
    n = 0;
    while (hq[st].size() > 0 && hq[st][hq[st].size() - 1].seq > ss) begin
      hent_t e;
      e = hq[st].pop_back();
      mmap[st][e.arch] = e.pv;
      fq.push_back(e.nw);
      n++;
    end
    do_cycle(st, 1, z, z, z, 0, 0, 0, 1, st, ss);
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      if (!sq_busy) break;
      cyc++;
      sq_valid = 0;
      in_valid = 2'b01; in_dst = '0;
      #1 chk(!rn_ready, "R10", int'(rn_ready), 0);
    end
    in_valid = '0;
    chk(cyc == n + 1, "R6", cyc, n + 1);
  endtask

  task automatic read_all(input int t);
    for (int i = 0; i < NA; i += 2) grp(t, 3, i, i + 1, 0, i + 1, i, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s1, sa [W], sb [W], d [W];
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    chk(out_valid == '0, "R9", int'(out_valid), 0);
    chk(sq_busy == 1'b0, "R6", int'(sq_busy), 0);
    chk(rn_ready == 1'b1, "R5", int'(rn_ready), 1);

    // Reset mapping of both threads.
    tag_src = "R1"; read_all(0);
    tag_src = "R8"; read_all(1);
    tag_src = "R4";

    // Index zero on both ports.
    tag_src = "R2"; tag_dst = "R2";
    grp(0, 3, 0, 0, 0, 0, 5, 0);
    tag_src = "R4"; tag_dst = "R3";

    // Group forwarding and own-destination isolation.
    grp(0, 3, 3, 3, 3, 3, 3, 3);
    grp(0, 3, 4, 0, 4, 4, 4, 5);
    tag_src = "R8"; read_all(1); tag_src = "R1";
    tag_src = "R4";

    // Fill thread 0 history to its limit.
    while (hq[0].size() < HD) grp(0, (HD - hq[0].size() >= 2) ? 3 : 1, 1, 2, 6, 6, 1, 7);
    grp(0, 1, 1, 1, 2, 0, 0, 0);             // history stall
    // Drain the pool with thread 1.
    while (fq.size() > 0) grp(1, (fq.size() >= 2) ? 3 : 1, 2, 3, 2, 2, 0, 5);
    grp(1, 1, 1, 1, 3, 0, 0, 0);             // pool stall
    tag_rdy = "R7";
    commit_only(0, 60000);                   // wrong number: ignored
    grp(1, 1, 1, 1, 3, 0, 0, 0);
    commit_only(0, hq[0][0].seq);            // frees one tag
    tag_dst = "R7";
    grp(1, 1, 1, 1, 3, 0, 0, 0);
    tag_dst = "R3"; tag_rdy = "R5";

    // Roll thread 1 back entirely, then a partial roll of thread 0.
    s1 = hq[1][0].seq - 1;
    squash(1, s1);
    tag_src = "R6"; read_all(1); read_all(0);
    squash(0, hq[0][HD / 2].seq);
    read_all(0);
    tag_src = "R4";

    // Random traffic.
    for (int it = 0; it < 3000; it++) begin
      int t, vld, ct, cs;
      bit cv;
      t = $urandom % NT;
      vld = $urandom % 4;
      for (int k = 0; k < W; k++) begin
        sa[k] = $urandom % NA; sb[k] = $urandom % NA;
        d[k] = ($urandom % 4 == 0) ? 0 : $urandom % NA;
      end
      cv = 0; ct = $urandom % NT; cs = 0;
      if ($urandom % 3 != 0 && hq[ct].size() > 0) begin
        cv = 1;
        cs = ($urandom % 8 == 0) ? hq[ct][0].seq + 1000 : hq[ct][0].seq;
      end
      if (it % 97 == 96) begin
        int st, ss;
        st = $urandom % NT;
        ss = (hq[st].size() > 0) ? hq[st][$urandom % hq[st].size()].seq : seqctr;
        squash(st, ss);
      end else begin
        do_cycle(t, vld, sa, sb, d, cv, ct, cs, 0, 0, 0);
      end
    end
    idle();
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule